// File: doc/BRIEF.md
# Multi-Channel Cardiac Rhythm Waveform Generator

This block synthesizes repeating heart-rhythm waveforms for exercising patient monitors and electrocardiographs. Eight rhythm shapes are defined on chip as sums of triangular pulses (with two special shapes for fibrillation). Each shape covers one period of 1024 points. A shared 10-bit phase accumulator walks through all eight shapes together. Four output channels carry 14-bit offset-binary codes for external converters.

Two pushbuttons pick which group of four rhythms appears on the channels. Both buttons are synchronized and debounced. A press latches its group until the other button is pressed. The step size sets the playback rate: a step of k moves k points per enabled clock, and the phase wraps modulo 1024 so the beat repeats without a seam.

Top module: `ecg_bank_gen`

## Requirements
- R1: After reset (rst_n low at a clock edge) all four channel outputs read 0, the phase is 0 and the button-one group is selected.
- R2: A channel code is the signed sample with its sign bit inverted (code = sample + 8192 modulo 16384), so a zero-amplitude point reads 8192 (0x2000).
- R3: On each rising edge with enable high, every channel registers the sample at the current phase and then the phase advances by phase_step modulo 1024. The n-th enabled edge after reset therefore shows point (n-1)*phase_step mod 1024, including past the wrap.
- R4: While enable is low, the phase and all four channel outputs hold their values, and playback resumes from the held phase.
- R5: With the button-one group selected, ch0..ch3 carry sinus tachycardia, supraventricular tachycardia, premature ventricular complex and atrial fibrillation.
- R6: With the button-two group selected, ch0..ch3 carry third-degree block, sinus bradycardia, ventricular fibrillation and first-degree block.
- R7: The selected group changes only on a debounced press. A repeated press of the same button keeps it, and a press of the other button switches it.
- R8: A button level shorter than DEB_CYCLES (default 64) synchronized cycles has no effect on the group.
- R9: Beat shapes are sums of triangles. A triangle with centre c, half-width h and peak p contributes p*(h-|a-c|)/h, truncated toward zero, where |a-c| < h, and 0 elsewhere. Flat intervals are exactly 0. Bradycardia: P(100,32,600), Q(200,8,-400), R(216,8,6000), S(232,8,-1200), T(420,64,1200), U(560,32,200).
- R10: Peak anchors: tachycardia R(262,8,6000); supraventricular R(112,8,5600) and T(250,64,1400); premature ventricular R(300,64,7000) and inverted T(560,64,-1500); atrial fibrillation R(300,8,6000) with no P wave; third-degree block R(300,16,5000) and a second P(600,32,600); first-degree block P(60,32,600) and R(346,8,6000).
- R11: The atrial fibrillation shape adds a ripple 10*|m-16|-80 for points a >= 640, where m = a mod 32.
- R12: The ventricular fibrillation shape is tw(a,128,2400)+tw(a,64,1200), where tw(a,P,A) = 2*A*|2*(a mod P)-P|/P - A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Advances phase and updates outputs when high |
| phase_step | input | 10 | Phase increment per enabled clock |
| btn_one | input | 1 | Raw pushbutton selecting the first rhythm group |
| btn_two | input | 1 | Raw pushbutton selecting the second rhythm group |
| ch0_code | output | 14 | Channel 0 offset-binary sample |
| ch1_code | output | 14 | Channel 1 offset-binary sample |
| ch2_code | output | 14 | Channel 2 offset-binary sample |
| ch3_code | output | 14 | Channel 3 offset-binary sample |

## Verification
The phase step is set equal to a target point, so the second enabled edge lands on that point. This reads wave peaks, part-slopes and flat intervals on every channel in both groups. A wrong centre, a wrong peak, a swapped channel mapping or a dropped sign-bit inversion each gives a different code. A step near 1024 is used to exercise the wrap. An idle stretch between edges shows whether the phase truly holds. Button patterns cover a short glitch, a repeated press of the same button and a switch back to the other group; each is read through a channel whose two candidate rhythms differ at the chosen point.

// File: rtl/ecg_pkg.sv
// Shared rhythm definitions: the wave parameters of each rhythm and the
// evaluation function that turns a table point into a signed amplitude.
// Assumes one period spans 1024 points; amplitudes are in LSBs of the
// output converter.
package ecg_pkg;

    localparam int NUM_RHYTHMS = 8;
    localparam int NUM_WAVES   = 7;   // P, second P, Q, R, S, T, U
    localparam int NUM_CH      = 4;

    typedef enum logic [1:0] {SHAPE_BEAT, SHAPE_RIPPLE_TAIL, SHAPE_CHAOTIC} shape_e;

    typedef struct packed {
        int centre;
        int half;
        int peak;
    } wave_t;

    typedef struct packed {
        shape_e                     kind;
        wave_t [NUM_WAVES-1:0]      w;
    } rhythm_t;

    function automatic wave_t mk(input int c, input int h, input int p);
        wave_t t;
        t.centre = c;
        t.half   = h;
        t.peak   = p;
        return t;
    endfunction

    // Rhythm index: 0 tachy, 1 SVT, 2 PVC, 3 AF, 4 third-degree block,
    // 5 VF, 6 brady, 7 first-degree block.
    function automatic rhythm_t spec_of(input int r);
        rhythm_t s;
        s.kind = SHAPE_BEAT;
        for (int i = 0; i < NUM_WAVES; i++) s.w[i] = mk(0, 1, 0);
        case (r)
            0: begin
                s.w[0] = mk(150, 32, 600);  s.w[2] = mk(246, 8, -400);
                s.w[3] = mk(262, 8, 6000);  s.w[4] = mk(278, 8, -1200);
                s.w[5] = mk(420, 64, 1200);
            end
            1: begin
                s.w[2] = mk(96, 8, -400);   s.w[3] = mk(112, 8, 5600);
                s.w[4] = mk(128, 8, -1000); s.w[5] = mk(250, 64, 1400);
            end
            2: begin
                s.w[3] = mk(300, 64, 7000); s.w[4] = mk(396, 32, -3000);
                s.w[5] = mk(560, 64, -1500);
            end
            3: begin
                s.kind = SHAPE_RIPPLE_TAIL;
                s.w[2] = mk(284, 8, -400);  s.w[3] = mk(300, 8, 6000);
                s.w[4] = mk(316, 8, -1200); s.w[5] = mk(480, 64, 1200);
            end
            4: begin
                s.w[0] = mk(80, 32, 600);   s.w[1] = mk(600, 32, 600);
                s.w[3] = mk(300, 16, 5000); s.w[5] = mk(480, 64, 1200);
            end
            5: s.kind = SHAPE_CHAOTIC;
            6: begin
                s.w[0] = mk(100, 32, 600);  s.w[2] = mk(200, 8, -400);
                s.w[3] = mk(216, 8, 6000);  s.w[4] = mk(232, 8, -1200);
                s.w[5] = mk(420, 64, 1200); s.w[6] = mk(560, 32, 200);
            end
            default: begin
                s.w[0] = mk(60, 32, 600);   s.w[2] = mk(330, 8, -400);
                s.w[3] = mk(346, 8, 6000);  s.w[4] = mk(362, 8, -1200);
                s.w[5] = mk(540, 64, 1200); s.w[6] = mk(680, 32, 200);
            end
        endcase
        return s;
    endfunction

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int tri_wave(input int a, input int per, input int amp);
        return (2 * amp * absv(2 * (a % per) - per)) / per - amp;
    endfunction

    // Amplitude of rhythm r at point a.
    function automatic int sample_at(input int r, input int a);
        rhythm_t s;
        int acc;
        int d;
        s   = spec_of(r);
        acc = 0;
        if (s.kind == SHAPE_CHAOTIC) begin
            acc = tri_wave(a, 128, 2400) + tri_wave(a, 64, 1200);
        end else begin
            for (int i = 0; i < NUM_WAVES; i++) begin
                d = absv(a - s.w[i].centre);
                if (s.w[i].peak != 0 && d < s.w[i].half)
                    acc += (s.w[i].peak * (s.w[i].half - d)) / s.w[i].half;
            end
            if (s.kind == SHAPE_RIPPLE_TAIL && a >= 640)
                acc += 10 * absv((a % 32) - 16) - 80;
        end
        return acc;
    endfunction

    // Rhythm carried on channel c while the second group is selected.
    function automatic int group_two_rhythm(input int c);
        case (c)
            0:       return 4;
            1:       return 6;
            2:       return 5;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/ecg_btn_filter.sv
// Pushbutton conditioner: two-flop synchronizer, then a level filter that
// accepts a new level only after it has stayed unchanged for DEB_CYCLES
// clocks. Emits a one-clock pulse on an accepted rising level.
// Assumes the raw button is asynchronous to clk.
module ecg_btn_filter #(
    parameter int DEB_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);

    logic             sync1, sync2;
    logic             level, level_d;
    logic [CNT_W-1:0] cnt;

    // Synchronize the raw button into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= btn_raw;
            sync2 <= sync1;
        end
    end

    // Accept a new level only after it persisted for DEB_CYCLES clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            level_d <= 1'b0;
            cnt     <= '0;
        end else begin
            level_d <= level;
            if (sync2 == level) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(DEB_CYCLES - 1)) begin
                level <= sync2;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign press = level & ~level_d;

    // R8: an accepted level always matches what the synchronizer showed.
    assert_filter_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == $past(sync2)));

endmodule

// File: rtl/ecg_phase_acc.sv
// Phase accumulator shared by all rhythm shapes. Advances by the step on
// each enabled clock and wraps modulo 2**ADDR_W. Assumes step is static or
// changes only between runs.
module ecg_phase_acc #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] phase
);
    // Advance the phase on enabled clocks, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= '0;
        else if (enable) phase <= phase + step;
    end

    // R4: phase holds while idle.
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(phase));

    // R3: a non-zero step always moves the phase.
    assert_phase_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && step != '0) |=> !$stable(phase));

endmodule

// File: rtl/ecg_shape_eval.sv
// Evaluates one rhythm shape at the given table point. Purely
// combinational; the shape is fixed at elaboration by RHYTHM.
// Assumes every shape stays inside the signed SAMPLE_W range.
module ecg_shape_eval
    import ecg_pkg::*;
#(
    parameter int RHYTHM   = 0,
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 14
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int MAX_V = 2 ** (SAMPLE_W - 1) - 1;
    localparam int MIN_V = -(2 ** (SAMPLE_W - 1));

    int value;

    // Compute the amplitude at the current point and check it fits.
    always_comb begin
        value  = sample_at(RHYTHM, int'(addr));
        sample = SAMPLE_W'(value);
        assert_sample_fits_R9: assert (value <= MAX_V && value >= MIN_V);
    end

endmodule

// File: rtl/ecg_bank_gen.sv
// Four-channel rhythm generator. Eight shapes are evaluated at a shared
// phase; a button-selected group routes four of them to the channel
// registers, which output offset-binary codes. Assumes synchronous
// active-low reset and raw (bouncing) buttons.
module ecg_bank_gen
    import ecg_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SAMPLE_W   = 14,
    parameter int DEB_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [ADDR_W-1:0]   phase_step,
    input  logic                btn_one,
    input  logic                btn_two,
    output logic [SAMPLE_W-1:0] ch0_code,
    output logic [SAMPLE_W-1:0] ch1_code,
    output logic [SAMPLE_W-1:0] ch2_code,
    output logic [SAMPLE_W-1:0] ch3_code
);
    logic [ADDR_W-1:0]          phase;
    logic [1:0]                 btn_raw;
    logic [1:0]                 press;
    logic                       group_two;
    logic signed [SAMPLE_W-1:0] shape [NUM_RHYTHMS];
    logic [SAMPLE_W-1:0]        code_q [NUM_CH];

    assign btn_raw = {btn_two, btn_one};

    ecg_phase_acc #(.ADDR_W(ADDR_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .step(phase_step), .phase(phase)
    );

    for (genvar b = 0; b < 2; b++) begin : g_btn
        ecg_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw[b]), .press(press[b])
        );
    end

    for (genvar r = 0; r < NUM_RHYTHMS; r++) begin : g_shape
        ecg_shape_eval #(.RHYTHM(r), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_eval (
            .addr(phase), .sample(shape[r])
        );
    end

    // Latch the selected group on a debounced press; button one wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)        group_two <= 1'b0;
        else if (press[0]) group_two <= 1'b0;
        else if (press[1]) group_two <= 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int SEL_ONE = c;
        localparam int SEL_TWO = group_two_rhythm(c);
        logic signed [SAMPLE_W-1:0] pick;

        assign pick = group_two ? shape[SEL_TWO] : shape[SEL_ONE];

        // Register the routed sample as an offset-binary code.
        always_ff @(posedge clk) begin
            if (!rst_n)      code_q[c] <= '0;
            else if (enable) code_q[c] <= {~pick[SAMPLE_W-1], pick[SAMPLE_W-2:0]};
        end
    end

    assign ch0_code = code_q[0];
    assign ch1_code = code_q[1];
    assign ch2_code = code_q[2];
    assign ch3_code = code_q[3];

    // R4: outputs hold while idle.
    assert_outputs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(ch0_code) && $stable(ch1_code) &&
                     $stable(ch2_code) && $stable(ch3_code)));

    // R7: the group only moves after a debounced press.
    assert_group_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (press == 2'b00) |=> $stable(group_two));

endmodule

// File: tb/sim_ecg_bank_gen.sv
module sim_ecg_bank_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [9:0]  phase_step = '0;
    logic        btn_one = 1'b0;
    logic        btn_two = 1'b0;
    logic [13:0] ch0_code, ch1_code, ch2_code, ch3_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ecg_bank_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .phase_step(phase_step),
        .btn_one(btn_one), .btn_two(btn_two),
        .ch0_code(ch0_code), .ch1_code(ch1_code),
        .ch2_code(ch2_code), .ch3_code(ch3_code)
    );

    function automatic int code_of(input int v);
        return (v + 8192) & 16383;
    endfunction

    function automatic int ch_val(input int c);
        case (c)
            0:       return int'(ch0_code);
            1:       return int'(ch1_code);
            2:       return int'(ch2_code);
            default: return int'(ch3_code);
        endcase
    endfunction

    task automatic check(input int c, input int exp, input string tag);
        int got;
        got = ch_val(c);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s ch%0d: got %0d expected %0d", tag, c, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; btn_one = 1'b0; btn_two = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic press(input bit second, input int hold);
        @(negedge clk);
        if (second) btn_two = 1'b1; else btn_one = 1'b1;
        repeat (hold) @(negedge clk);
        btn_one = 1'b0; btn_two = 1'b0;
        repeat (120) @(negedge clk);
    endtask

    task automatic run_edges(input int step, input int n);
        @(negedge clk);
        phase_step = 10'(step);
        enable = 1'b1;
        repeat (n) @(negedge clk);
        enable = 1'b0;
    endtask

    // Reset, pick a group, land on one point, compare one channel.
    task automatic point(input bit second, input int a, input int c, input int v, input string tag);
        do_reset();
        if (second) press(1'b1, 100);
        run_edges(a, 2);
        check(c, code_of(v), tag);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        for (int c = 0; c < 4; c++) check(c, 0, "R1 reset");
    endtask

    task automatic t_group_one();
        point(1'b0, 262, 0, 6000, "R5 R10 tachy R");
        point(1'b0, 112, 1, 5600, "R5 R10 svt R");
        point(1'b0, 300, 2, 7000, "R5 R10 pvc R");
        point(1'b0, 560, 2, -1500, "R2 R10 pvc inverted T");
        point(1'b0, 300, 3, 6000, "R5 R10 af R");
        point(1'b0, 640, 3, 80, "R11 af ripple");
    endtask

    task automatic t_group_two();
        point(1'b1, 300, 0, 5000, "R6 R10 avb3 R");
        point(1'b1, 600, 0, 600, "R6 R10 avb3 second P");
        point(1'b1, 216, 1, 6000, "R6 R9 brady R");
        point(1'b1, 300, 1, 0, "R2 R9 brady flat ST");
        point(1'b1, 116, 1, 300, "R9 brady P slope");
        point(1'b1, 16, 2, 1200, "R6 R12 vf");
        point(1'b1, 32, 2, -1200, "R12 vf");
        point(1'b1, 346, 3, 6000, "R6 R10 avb1 R");
        point(1'b1, 200, 3, 0, "R9 avb1 flat PR");
    endtask

    task automatic t_wrap();
        do_reset();
        run_edges(1000, 2);
        check(3, code_of(0), "R3 point 1000");
        run_edges(1000, 1);
        check(3, code_of(-80), "R3 R11 wrap to 976");
    endtask

    task automatic t_hold();
        do_reset();
        press(1'b1, 100);
        run_edges(100, 2);
        check(1, code_of(600), "R4 before idle");
        repeat (10) @(negedge clk);
        check(1, code_of(600), "R4 idle hold");
        run_edges(100, 1);
        check(1, code_of(-400), "R4 resume from held phase");
    endtask

    task automatic t_glitch();
        do_reset();
        press(1'b1, 20);
        run_edges(216, 2);
        check(1, code_of(656), "R8 glitch ignored");
    endtask

    task automatic t_repeat();
        do_reset();
        press(1'b1, 100);
        press(1'b1, 100);
        run_edges(216, 2);
        check(1, code_of(6000), "R7 repeat press keeps group");
        press(1'b0, 100);
        run_edges(0, 1);
        check(1, code_of(0), "R7 switch to group one");
    endtask

    initial begin
        t_reset();
        t_group_one();
        t_group_two();
        t_wrap();
        t_hold();
        t_glitch();
        t_repeat();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule